// File: doc/BRIEF.md
# Configuration Image Clock-to-Data Ratio Detector

This block sits beside a configuration data path and watches the 32-bit words of a configuration image as they stream past. Two fixed header words carry the information it needs. One word holds a two-bit encryption mode field, and a later word holds an active-low compression bit. From these two indications and the selected port width (16 or 32 bits), the block works out the 2-bit code for the ratio of configuration clocks to data words. Control logic can then program that code before the payload is clocked into the fabric.

A start pulse opens a new image and clears all earlier results. Words are counted only when their valid strobe is high. The word flagged as last closes the image. If the image closes before the compression word has arrived, the block raises a sticky error instead of a ratio. The word positions, field bits and compression polarity are parameters.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, ratio_vld, short_err and ratio_code are all 0, and ratio_code reads 0 whenever ratio_vld is low.
- R2: The image counts as encrypted when bits [3:2] of word index 69 (counting from 0) hold any nonzero value. The other bits of that word have no effect.
- R3: The image counts as compressed when bit 1 of word index 229 is 0. A 1 in that bit means uncompressed.
- R4: An image that is neither encrypted nor compressed gives ratio_code 0 (x1) at both widths.
- R5: A compressed image gives code 2 (x4) when wide_sel=0 (16-bit) and code 3 (x8) when wide_sel=1 (32-bit), whether or not it is also encrypted.
- R6: An image that is encrypted but not compressed gives code 1 (x2) when wide_sel=0 and code 2 (x4) when wide_sel=1.
- R7: ratio_vld is low up to and including the cycle in which word 229 is accepted. It is high from the next cycle, and it stays high with ratio_code unchanged until the next sof pulse.
- R8: If the word accepted with word_last has an index below 229, short_err goes high on the following cycle and stays high until the next sof. ratio_vld stays low for that image. An image whose last word is index 229 gives no error.
- R9: An sof pulse clears ratio_vld, ratio_code and short_err on the next cycle and restarts word counting. A word accepted in the same cycle as sof is index 0 of the new image.
- R10: Words presented after reset but before any sof, or after the last word of an image, are ignored. They produce neither a ratio nor an error change.
- R11: wide_sel is sampled only in the cycle that word 229 is accepted. Changing it afterwards does not change ratio_code.
- R12: Cycles with word_vld low do not advance the word index. Idle gaps between words do not shift which words are decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-image pulse |
| word_vld | input | 1 | Word strobe |
| word_last | input | 1 | Marks the final word of the image (qualified by word_vld) |
| word_data | input | DATA_W (32) | Configuration image word |
| wide_sel | input | 1 | Port width: 1 = 32-bit, 0 = 16-bit |
| ratio_code | output | 2 | Clock-to-data ratio code: 0=x1, 1=x2, 2=x4, 3=x8 |
| ratio_vld | output | 1 | ratio_code is valid for the current image |
| short_err | output | 1 | Image ended before the compression word |

## Verification
The hardest situation to reach from the ports is a word index that is off by one or fails to restart. The word that decides compression lies more than two hundred words into the stream, so a small slip shows only in a full-length image. The stimulus therefore streams whole images with idle gaps and restarts an image part-way through. It records ratio_vld just before and just after word 229 so that an early or late decode is visible. Short images ending at index 228 and 229 pin down the error boundary. A stream of stray words after a closed image shows whether the counter really stopped.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

   typedef enum logic [1:0] {
      RATIO_X1 = 2'd0,
      RATIO_X2 = 2'd1,
      RATIO_X4 = 2'd2,
      RATIO_X8 = 2'd3
   } ratio_e;

   // Compressed images start at x4, encrypted-only at x2; the wide port
   // doubles the ratio by stepping the code once.
   function automatic ratio_e pick_ratio(input logic enc, input logic comp,
                                         input logic wide);
      logic [1:0] base;
      if (!enc && !comp) begin
         return RATIO_X1;
      end
      base = comp ? 2'd2 : 2'd1;
      return ratio_e'(base + {1'b0, wide});
   endfunction

endpackage

// File: rtl/hdr_word_tracker.sv
module hdr_word_tracker #(
   parameter int ENC_IDX  = 69,
   parameter int COMP_IDX = 229
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof,
   input  logic word_vld,
   input  logic word_last,
   output logic at_enc,
   output logic at_comp,
   output logic short_end
);

   localparam int CNT_W = $clog2(COMP_IDX + 2);
   localparam logic [CNT_W-1:0] ENC_POS  = CNT_W'(ENC_IDX);
   localparam logic [CNT_W-1:0] COMP_POS = CNT_W'(COMP_IDX);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(COMP_IDX + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur_idx;
   logic             open_q;
   logic             accept;

   assign accept  = word_vld && (sof || open_q);
   assign cur_idx = sof ? '0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         open_q <= 1'b0;
      end else begin
         if (accept && word_last) begin
            open_q <= 1'b0;
         end else if (sof) begin
            open_q <= 1'b1;
         end
         if (accept && (cur_idx != CNT_MAX)) begin
            cnt_q <= cur_idx + CNT_W'(1);
         end else if (sof) begin
            cnt_q <= '0;
         end
      end
   end

   assign at_enc    = accept && (cur_idx == ENC_POS);
   assign at_comp   = accept && (cur_idx == COMP_POS);
   assign short_end = accept && word_last && (cur_idx < COMP_POS);

   // Words without a strobe never reach the decoders
   assert_idle_no_decode_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> (!at_enc && !at_comp && !short_end));

   // Once the image is closed, no decode until a new start
   assert_closed_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && word_last && !sof) |=> (!sof |-> (!at_comp && !short_end)));

endmodule

// File: rtl/hdr_field_capture.sv
module hdr_field_capture #(
   parameter int DATA_W          = 32,
   parameter int ENC_LO          = 2,
   parameter int ENC_HI          = 3,
   parameter int COMP_BIT        = 1,
   parameter bit COMP_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic              at_enc,
   input  logic [DATA_W-1:0] word_data,
   output logic              enc_flag,
   output logic              comp_now
);

   localparam int ENC_W = ENC_HI - ENC_LO + 1;

   logic [ENC_W-1:0] enc_or;
   logic             enc_hit;
   logic             unused_bits;

   assign unused_bits = ^word_data;

   // OR-reduce the encryption mode field bit by bit
   genvar gi;
   generate
      for (gi = 0; gi < ENC_W; gi++) begin : g_enc_or
         if (gi == 0) begin : g_first
            assign enc_or[gi] = word_data[ENC_LO];
         end else begin : g_rest
            assign enc_or[gi] = enc_or[gi-1] | word_data[ENC_LO + gi];
         end
      end
   endgenerate
   assign enc_hit = enc_or[ENC_W-1];

   // Compression bit polarity variant
   generate
      if (COMP_ACTIVE_LOW) begin : g_comp_low
         assign comp_now = ~word_data[COMP_BIT];
      end else begin : g_comp_high
         assign comp_now = word_data[COMP_BIT];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enc_flag <= 1'b0;
      end else if (at_enc) begin
         enc_flag <= enc_hit;
      end else if (sof) begin
         enc_flag <= 1'b0;
      end
   end

   // Encryption indication is only taken from the header word
   assert_enc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!at_enc && !sof) |=> $stable(enc_flag));

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
   import hdr_ratio_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int ENC_IDX         = 69,
   parameter int ENC_LO          = 2,
   parameter int ENC_HI          = 3,
   parameter int COMP_IDX        = 229,
   parameter int COMP_BIT        = 1,
   parameter bit COMP_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic              word_vld,
   input  logic              word_last,
   input  logic [DATA_W-1:0] word_data,
   input  logic              wide_sel,
   output logic [1:0]        ratio_code,
   output logic              ratio_vld,
   output logic              short_err
);

   generate
      if (ENC_IDX < 0 || ENC_IDX >= COMP_IDX) begin : g_bad_order
         $error("encryption word must precede the compression word");
      end
      if (ENC_LO > ENC_HI || ENC_HI >= DATA_W) begin : g_bad_enc
         $error("encryption field outside the data word");
      end
      if (COMP_BIT < 0 || COMP_BIT >= DATA_W) begin : g_bad_comp
         $error("compression bit outside the data word");
      end
   endgenerate

   logic   at_enc;
   logic   at_comp;
   logic   short_end;
   logic   enc_flag;
   logic   comp_now;
   ratio_e ratio_q;
   logic   vld_q;
   logic   err_q;

   hdr_word_tracker #(
      .ENC_IDX  (ENC_IDX),
      .COMP_IDX (COMP_IDX)
   ) tracker_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (sof),
      .word_vld  (word_vld),
      .word_last (word_last),
      .at_enc    (at_enc),
      .at_comp   (at_comp),
      .short_end (short_end)
   );

   hdr_field_capture #(
      .DATA_W          (DATA_W),
      .ENC_LO          (ENC_LO),
      .ENC_HI          (ENC_HI),
      .COMP_BIT        (COMP_BIT),
      .COMP_ACTIVE_LOW (COMP_ACTIVE_LOW)
   ) capture_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (sof),
      .at_enc    (at_enc),
      .word_data (word_data),
      .enc_flag  (enc_flag),
      .comp_now  (comp_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= RATIO_X1;
         vld_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (sof) begin
            ratio_q <= RATIO_X1;
            vld_q   <= 1'b0;
            err_q   <= 1'b0;
         end
         if (at_comp) begin
            ratio_q <= pick_ratio(enc_flag, comp_now, wide_sel);
            vld_q   <= 1'b1;
         end
         if (short_end) begin
            err_q <= 1'b1;
         end
      end
   end

   assign ratio_code = ratio_q;
   assign ratio_vld  = vld_q;
   assign short_err  = err_q;

   assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ratio_vld |-> (ratio_code == 2'd0));

   assert_plain_x1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ratio_vld) |-> ((ratio_code == 2'd0) == $past(!enc_flag && !comp_now)));

   assert_comp_min_x4_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ratio_vld) && $past(comp_now)) |-> ratio_code[1]);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_vld && !sof) |=> (ratio_vld && $stable(ratio_code)));

   assert_vld_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ratio_vld && short_err));

   assert_sof_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && !(word_vld && word_last)) |=> (!ratio_vld && !short_err));

endmodule

// File: tb/hdr_ratio_detect_tb_top.sv
module hdr_ratio_detect_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof = 1'b0;
   logic        word_vld = 1'b0;
   logic        word_last = 1'b0;
   logic [31:0] word_data = '0;
   logic        wide_sel = 1'b0;
   logic [1:0]  ratio_code;
   logic        ratio_vld;
   logic        short_err;

   int checks = 0;
   int fails  = 0;

   logic       pre_vld, obs_vld, obs_err, end_vld, end_err;
   logic [1:0] obs_code, end_code;

   always #4 clk = ~clk;

   hdr_ratio_detect dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof        (sof),
      .word_vld   (word_vld),
      .word_last  (word_last),
      .word_data  (word_data),
      .wide_sel   (wide_sel),
      .ratio_code (ratio_code),
      .ratio_vld  (ratio_vld),
      .short_err  (short_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_code(input logic enc, input logic comp, input logic wide);
      if (!enc && !comp) return 2'd0;
      return (comp ? 2'd2 : 2'd1) + {1'b0, wide};
   endfunction

   // Called at a negedge; returns at the following negedge
   task automatic push(input logic [31:0] d, input logic lst, input logic with_sof);
      word_vld  = 1'b1;
      word_data = d;
      word_last = lst;
      sof       = with_sof;
      @(negedge clk);
      word_vld  = 1'b0;
      word_last = 1'b0;
      sof       = 1'b0;
      word_data = 32'hDEAD_BEEF;
   endtask

   task automatic pulse_sof();
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
   endtask

   task automatic stream(input logic [1:0] encf, input logic cbit, input logic wide,
                         input int nwords, input logic sof_first, input int gap,
                         input logic flip_wide, input logic with_last);
      if (!sof_first) pulse_sof();
      wide_sel = wide;
      for (int i = 0; i < nwords; i++) begin
         logic [31:0] d;
         d = {16'h5A3C, 16'(i)};
         if (i == 69)  d[3:2] = encf;
         if (i == 229) d[1]   = cbit;
         if (i == 229) pre_vld = ratio_vld;
         push(d, with_last && (i == nwords - 1), sof_first && (i == 0));
         if (i == 229) begin
            obs_vld  = ratio_vld;
            obs_code = ratio_code;
            obs_err  = short_err;
            if (flip_wide) wide_sel = ~wide;
         end
         for (int g = 0; g < gap; g++) @(negedge clk);
      end
      end_vld  = ratio_vld;
      end_code = ratio_code;
      end_err  = short_err;
   endtask

   task automatic full_image(input string req, input logic [1:0] encf, input logic cbit,
                             input logic wide, input int gap);
      stream(encf, cbit, wide, 240, 1'b0, gap, 1'b0, 1'b1);
      chk({req, " R7 vld low before word 229"}, pre_vld, 1'b0);
      chk({req, " R7 vld after word 229"}, obs_vld, 1'b1);
      chk({req, " code"}, obs_code, exp_code(encf != 2'b00, !cbit, wide));
      chk({req, " R7 code held at end"}, end_code, obs_code);
      chk({req, " R8 no error"}, end_err, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 reset vld", ratio_vld, 1'b0);
      chk("R1 reset err", short_err, 1'b0);
      chk("R1 reset code", ratio_code, 2'd0);
   endtask

   task automatic t_before_sof();
      for (int i = 0; i < 240; i++) push({16'h0000, 16'(i)}, 1'b0, 1'b0);
      chk("R10 words before sof ignored vld", ratio_vld, 1'b0);
      chk("R10 words before sof ignored err", short_err, 1'b0);
   endtask

   task automatic t_plain();
      full_image("R4 plain 16", 2'b00, 1'b1, 1'b0, 0);
      full_image("R4 plain 32", 2'b00, 1'b1, 1'b1, 0);
   endtask

   task automatic t_enc();
      full_image("R2 R6 enc=01 16", 2'b01, 1'b1, 1'b0, 0);
      full_image("R2 R6 enc=10 32", 2'b10, 1'b1, 1'b1, 0);
      full_image("R2 R6 enc=11 16", 2'b11, 1'b1, 1'b0, 0);
   endtask

   task automatic t_comp();
      full_image("R3 R5 comp 16", 2'b00, 1'b0, 1'b0, 0);
      full_image("R3 R5 comp 32", 2'b00, 1'b0, 1'b1, 0);
      full_image("R5 enc+comp 16", 2'b11, 1'b0, 1'b0, 0);
      full_image("R5 enc+comp 32", 2'b01, 1'b0, 1'b1, 0);
   endtask

   task automatic t_hold_and_clear();
      full_image("R7 hold", 2'b10, 1'b1, 1'b0, 0);
      repeat (20) @(negedge clk);
      chk("R7 vld still high", ratio_vld, 1'b1);
      chk("R7 code still 1", ratio_code, 2'd1);
      pulse_sof();
      chk("R9 sof clears vld", ratio_vld, 1'b0);
      chk("R9 sof clears code", ratio_code, 2'd0);
   endtask

   task automatic t_wide_late();
      stream(2'b00, 1'b0, 1'b0, 240, 1'b0, 0, 1'b1, 1'b1);
      chk("R11 code after late wide change", end_code, 2'd2);
      stream(2'b01, 1'b1, 1'b1, 240, 1'b0, 0, 1'b1, 1'b1);
      chk("R11 code after late narrow change", end_code, 2'd2);
   endtask

   task automatic t_gaps();
      full_image("R12 gaps comp 32", 2'b00, 1'b0, 1'b1, 2);
      full_image("R12 gaps enc 16", 2'b10, 1'b1, 1'b0, 1);
   endtask

   task automatic t_short();
      stream(2'b00, 1'b0, 1'b0, 229, 1'b0, 0, 1'b0, 1'b1);
      chk("R8 last at 228 gives error", end_err, 1'b1);
      chk("R8 last at 228 no vld", end_vld, 1'b0);
      repeat (5) @(negedge clk);
      chk("R8 error held", short_err, 1'b1);
      for (int i = 0; i < 250; i++) push(32'h0000_0000, 1'b0, 1'b0);
      chk("R10 words after last ignored vld", ratio_vld, 1'b0);
      chk("R10 words after last keep err", short_err, 1'b1);
      pulse_sof();
      chk("R9 sof clears error", short_err, 1'b0);
      stream(2'b00, 1'b0, 1'b1, 230, 1'b0, 0, 1'b0, 1'b1);
      chk("R8 last at 229 no error", end_err, 1'b0);
      chk("R8 last at 229 vld", end_vld, 1'b1);
      chk("R8 last at 229 code", end_code, 2'd3);
      stream(2'b00, 1'b1, 1'b0, 1, 1'b1, 0, 1'b0, 1'b1);
      chk("R8 R9 single word with sof gives error", end_err, 1'b1);
      chk("R9 single word with sof clears vld", end_vld, 1'b0);
   endtask

   task automatic t_restart();
      stream(2'b11, 1'b0, 1'b1, 150, 1'b0, 0, 1'b0, 1'b0);
      stream(2'b10, 1'b1, 1'b0, 240, 1'b1, 0, 1'b0, 1'b1);
      chk("R9 restart vld low before word 229", pre_vld, 1'b0);
      chk("R9 restart vld after word 229", obs_vld, 1'b1);
      chk("R9 restart code", obs_code, 2'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_before_sof();
      t_plain();
      t_enc();
      t_comp();
      t_hold_and_clear();
      t_wide_late();
      t_gaps();
      t_short();
      t_restart();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule